// File: doc/BRIEF.md
# I2C Multi-Master Bus Access Controller

This block is the bus-access layer of an I2C master that shares its clock and data lines with other masters and with slaves. It never drives a line high: each line is represented by a pull-low enable going out and a sampled line level coming in, and an external wired-AND combines all devices. Both sampled lines pass through a synchroniser. START and STOP conditions are decoded from the synchronised pair, whoever drives them, and a busy flag is kept from them.

A small command port drives a transfer. The host asks for a START, one or more byte writes (address or data, sent MSB first and followed by an acknowledge bit), and a STOP. Each command ends with a one-cycle `done` pulse. When `done` pulses, `ack` and `lost` describe the outcome. While the block owns the bus it takes part in clock synchronisation: it holds its clock low for its own low count, and its high count does not start until the line is really high. On every data bit it leaves released, it compares the line with what it sent. A mismatch means another master won. The block then lets go of both lines at once and stays off the bus until a STOP clears the busy flag.

Top module: `i2c_mm_master`

## Requirements
- R1: The block only ever pulls a line low or releases it; after reset and whenever no transfer is in progress, both `scl_pull` and `sda_pull` are 0.
- R2: `bus_busy` goes to 1 when SDA is seen falling while SCL is high (START) and returns to 0 when SDA is seen rising while SCL is high (STOP), for conditions made by any device.
- R3: A START command given while `bus_busy` is 1 does not touch either line; the block waits until the bus is free and then makes its START.
- R4: A START pulls SDA low while SCL is high, keeps SCL released for HIGH_CNT+1 cycles, then pulls SCL low and pulses `done`, leaving SCL held low.
- R5: Unless another device stretches it, each low phase the block drives lasts LOW_CNT+1 cycles.
- R6: After the block releases SCL, its high count starts only once the synchronised SCL reads high. Each SCL high phase therefore lasts HIGH_CNT+4 cycles from the line rising, however long a slave held the line low.
- R7: A write command (`cmd_op` = 1) sends `cmd_data` MSB first, followed by a released acknowledge bit. `ack` is 1 when the addressed device pulled SDA low during that bit, and 0 otherwise.
- R8: If SDA reads low while SCL is high during a data bit that the block released, the block sets `lost`, releases both lines in that same cycle and pulses `done`. No check is made during the acknowledge bit.
- R9: Two masters sending identical bits both complete with `lost` = 0; the one whose byte first carries a 0 where the other has a 1 wins.
- R10: `lost` stays 1 until the next command is accepted. A master that has lost drives no STOP and leaves both lines released.
- R11: A STOP command (`cmd_op` = 2) pulls SDA low, releases SCL, waits for the line high and HIGH_CNT+1 cycles, releases SDA, and after another HIGH_CNT+1 cycles pulses `done`; `bus_busy` is then 0.
- R12: A command that does not fit the current phase (write or stop with no START made, START while the bus is held; `cmd_op` = 0 is START) pulses `done` one cycle after acceptance and changes neither line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 0 START, 1 write byte, 2 STOP |
| cmd_data | input | 8 | Byte to send for a write |
| cmd_ready | output | 1 | Block can take a command (idle or holding the bus) |
| done | output | 1 | One-cycle pulse at the end of a command |
| ack | output | 1 | Acknowledge seen on the last write |
| lost | output | 1 | Arbitration lost; sticky until the next accepted command |
| bus_busy | output | 1 | A START has been seen without a following STOP |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
The bench applies every input on a falling clock edge and reads every output on a falling clock edge. Each result is due a fixed number of cycles after its stimulus. A rejected command raises `done` at the first sample after the accepting edge. `bus_busy` follows a bus condition three cycles later, because of the two synchroniser flops and the edge register. An SCL high phase is HIGH_CNT+4 cycles and a driven low phase is LOW_CNT+1 cycles. Phase lengths are measured on the modelled wired-AND bus. The bench allows one cycle of slack only where the behavioural slave releases the line on a falling edge. `lost`, `done` and the released lines are checked together in the sample where `done` appears.

// File: rtl/i2cmm_pkg.sv
package i2cmm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_STA_HOLD,
        ST_PARK,
        ST_BIT_LOW,
        ST_BIT_REL,
        ST_BIT_HIGH,
        ST_STO_LOW,
        ST_STO_REL,
        ST_STO_HIGH,
        ST_STO_FREE
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    localparam int BYTE_BITS = 8;

    function automatic logic is_start(lines_t prv, lines_t cur);
        return prv.scl & cur.scl & prv.sda & ~cur.sda;
    endfunction

    function automatic logic is_stop(lines_t prv, lines_t cur);
        return prv.scl & cur.scl & ~prv.sda & cur.sda;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/i2cmm_line_mon.sv
module i2cmm_line_mon
    import i2cmm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   scl_i,
    input  logic   sda_i,
    output lines_t lines,
    output logic   busy
);
    logic [SYNC_STAGES-1:0] scl_st;
    logic [SYNC_STAGES-1:0] sda_st;
    lines_t                 prev;
    logic                   start_seen;
    logic                   stop_seen;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_st <= '1;
                    sda_st <= '1;
                end else begin
                    scl_st <= {scl_st[SYNC_STAGES-2:0], scl_i};
                    sda_st <= {sda_st[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_st <= '1;
                    sda_st <= '1;
                end else begin
                    scl_st <= scl_i;
                    sda_st <= sda_i;
                end
            end
        end
    endgenerate

    assign lines.scl  = scl_st[SYNC_STAGES-1];
    assign lines.sda  = sda_st[SYNC_STAGES-1];
    assign start_seen = is_start(prev, lines);
    assign stop_seen  = is_stop(prev, lines);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
            busy <= 1'b0;
        end else begin
            prev <= lines;
            if (start_seen)
                busy <= 1'b1;
            else if (stop_seen)
                busy <= 1'b0;
        end
    end

    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> busy);
    p_stop_clears_busy_r2: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !busy);

endmodule

// File: rtl/i2cmm_phase_tmr.sv
module i2cmm_phase_tmr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // r5: an idle counter never wraps around
    p_tmr_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/i2c_mm_master.sv
module i2c_mm_master
    import i2cmm_pkg::*;
#(
    parameter int LOW_CNT     = 8,
    parameter int HIGH_CNT    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_data,
    output logic       cmd_ready,
    output logic       done,
    output logic       ack,
    output logic       lost,
    output logic       bus_busy,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull,
    output logic       sda_pull
);
    localparam int            CW      = $clog2(max2(LOW_CNT, HIGH_CNT) + 1);
    localparam logic [CW-1:0] LOW_V   = CW'(LOW_CNT);
    localparam logic [CW-1:0] HIGH_V  = CW'(HIGH_CNT);
    localparam logic [3:0]    ACK_IDX = 4'(BYTE_BITS);

    phase_e        st, st_n;
    lines_t        lines;
    logic [7:0]    shreg, sh_n;
    logic [3:0]    bitidx, bi_n;
    logic          scl_n, sda_n, done_n, ack_n, lost_n;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    op_e           op_in;

    assign op_in = op_e'(cmd_op);

    i2cmm_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .lines(lines), .busy(bus_busy)
    );

    i2cmm_phase_tmr #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_zero)
    );

    assign cmd_ready = (st == ST_IDLE) || (st == ST_PARK);

    always_comb begin
        st_n     = st;
        scl_n    = scl_pull;
        sda_n    = sda_pull;
        sh_n     = shreg;
        bi_n     = bitidx;
        done_n   = 1'b0;
        ack_n    = ack;
        lost_n   = lost;
        tmr_load = 1'b0;
        tmr_val  = HIGH_V;
        unique case (st)
            ST_IDLE: begin
                scl_n = 1'b0;
                sda_n = 1'b0;
                if (cmd_valid) begin
                    lost_n = 1'b0;
                    ack_n  = 1'b0;
                    if (op_in == OP_START) st_n = ST_WAIT_FREE;
                    else                   done_n = 1'b1;
                end
            end
            ST_WAIT_FREE: begin
                if (!bus_busy && lines.scl && lines.sda) begin
                    sda_n    = 1'b1;
                    tmr_load = 1'b1;
                    st_n     = ST_STA_HOLD;
                end
            end
            ST_STA_HOLD: begin
                if (tmr_zero) begin
                    scl_n  = 1'b1;
                    done_n = 1'b1;
                    st_n   = ST_PARK;
                end
            end
            ST_PARK: begin
                if (cmd_valid) begin
                    lost_n = 1'b0;
                    ack_n  = 1'b0;
                    tmr_val = LOW_V;
                    if (op_in == OP_WRITE) begin
                        sh_n     = cmd_data;
                        bi_n     = '0;
                        tmr_load = 1'b1;
                        st_n     = ST_BIT_LOW;
                    end else if (op_in == OP_STOP) begin
                        sda_n    = 1'b1;
                        tmr_load = 1'b1;
                        st_n     = ST_STO_LOW;
                    end else begin
                        done_n = 1'b1;
                    end
                end
            end
            ST_BIT_LOW: begin
                sda_n = (bitidx == ACK_IDX) ? 1'b0 : ~shreg[7];
                if (tmr_zero) begin
                    scl_n = 1'b0;
                    st_n  = ST_BIT_REL;
                end
            end
            ST_BIT_REL: begin
                if (lines.scl) begin
                    tmr_load = 1'b1;
                    st_n     = ST_BIT_HIGH;
                end
            end
            ST_BIT_HIGH: begin
                if ((bitidx < ACK_IDX) && !sda_pull && lines.scl && !lines.sda) begin
                    lost_n = 1'b1;
                    scl_n  = 1'b0;
                    sda_n  = 1'b0;
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end else if (tmr_zero) begin
                    scl_n    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LOW_V;
                    if (bitidx == ACK_IDX) begin
                        ack_n  = ~lines.sda;
                        done_n = 1'b1;
                        st_n   = ST_PARK;
                    end else begin
                        bi_n = bitidx + 1'b1;
                        sh_n = {shreg[6:0], 1'b0};
                        st_n = ST_BIT_LOW;
                    end
                end
            end
            ST_STO_LOW: begin
                if (tmr_zero) begin
                    scl_n = 1'b0;
                    st_n  = ST_STO_REL;
                end
            end
            ST_STO_REL: begin
                if (lines.scl) begin
                    tmr_load = 1'b1;
                    st_n     = ST_STO_HIGH;
                end
            end
            ST_STO_HIGH: begin
                if (tmr_zero) begin
                    sda_n    = 1'b0;
                    tmr_load = 1'b1;
                    st_n     = ST_STO_FREE;
                end
            end
            ST_STO_FREE: begin
                if (tmr_zero) begin
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            shreg    <= '0;
            bitidx   <= '0;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            done     <= 1'b0;
            ack      <= 1'b0;
            lost     <= 1'b0;
        end else begin
            st       <= st_n;
            shreg    <= sh_n;
            bitidx   <= bi_n;
            scl_pull <= scl_n;
            sda_pull <= sda_n;
            done     <= done_n;
            ack      <= ack_n;
            lost     <= lost_n;
        end
    end

    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!scl_pull && !sda_pull));
    p_sda_steady_high_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT_HIGH && $past(st) == ST_BIT_HIGH) |-> $stable(sda_pull));
    p_lost_release_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> (!scl_pull && !sda_pull));
    p_lost_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> done);

endmodule

// File: tb/i2c_mm_master_tb_top.sv
module i2c_mm_master_tb_top;
    localparam int LOW  = 8;
    localparam int HIGH = 8;
    localparam logic [1:0] OPS = 2'd0, OPW = 2'd1, OPP = 2'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]      cv = '0;
    logic [1:0][1:0] cop = '0;
    logic [1:0][7:0] cdat = '0;
    logic [1:0] rdy, dn, ak, ls, bz, sclp, sdap;
    logic slv_scl, slv_sda;
    wire  bus_scl = ~(sclp[0] | sclp[1] | slv_scl);
    wire  bus_sda = ~(sdap[0] | sdap[1] | slv_sda);

    i2c_mm_master #(.LOW_CNT(LOW), .HIGH_CNT(HIGH)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cv[0]), .cmd_op(cop[0]), .cmd_data(cdat[0]),
        .cmd_ready(rdy[0]), .done(dn[0]), .ack(ak[0]), .lost(ls[0]), .bus_busy(bz[0]),
        .scl_i(bus_scl), .sda_i(bus_sda), .scl_pull(sclp[0]), .sda_pull(sdap[0]));

    i2c_mm_master #(.LOW_CNT(LOW), .HIGH_CNT(HIGH)) m2_i (
        .clk(clk), .rst(rst), .cmd_valid(cv[1]), .cmd_op(cop[1]), .cmd_data(cdat[1]),
        .cmd_ready(rdy[1]), .done(dn[1]), .ack(ak[1]), .lost(ls[1]), .bus_busy(bz[1]),
        .scl_i(bus_scl), .sda_i(bus_sda), .scl_pull(sclp[1]), .sda_pull(sdap[1]));

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural slave on the wired-AND bus
    bit         ack_en = 1'b1;
    int         stretch_n = 0;
    logic       scl_q, sda_q, s_active;
    logic [7:0] s_shift, s_byte;
    int         s_bits, s_cnt, s_nbytes;

    always @(negedge clk) begin
        if (rst) begin
            scl_q <= 1'b1; sda_q <= 1'b1; s_active <= 1'b0;
            slv_scl <= 1'b0; slv_sda <= 1'b0;
            s_shift <= '0; s_byte <= '0; s_bits <= 0; s_cnt <= 0; s_nbytes <= 0;
        end else begin
            scl_q <= bus_scl;
            sda_q <= bus_sda;
            if (s_cnt > 1) s_cnt <= s_cnt - 1;
            else if (s_cnt == 1) begin s_cnt <= 0; slv_scl <= 1'b0; end
            if (scl_q && bus_scl && sda_q && !bus_sda) begin
                s_active <= 1'b1; s_bits <= 0; slv_sda <= 1'b0;
            end else if (scl_q && bus_scl && !sda_q && bus_sda) begin
                s_active <= 1'b0;
            end else if (s_active && !scl_q && bus_scl) begin
                if (s_bits < 8) begin
                    s_shift <= {s_shift[6:0], bus_sda};
                    s_bits  <= s_bits + 1;
                end
            end else if (s_active && scl_q && !bus_scl) begin
                if (stretch_n > 0) begin slv_scl <= 1'b1; s_cnt <= stretch_n; end
                if (s_bits == 8) begin
                    slv_sda <= ack_en; s_byte <= s_shift;
                    s_nbytes <= s_nbytes + 1; s_bits <= 9;
                end else if (s_bits == 9) begin
                    slv_sda <= 1'b0; s_bits <= 0;
                end
            end
        end
    end

    // bus clock phase monitor
    bit   mon_clr = 1'b1;
    logic mprev;
    int   hi_run, lo_run, hi_min, hi_max, lo_max;
    bit   seen_r, seen_f;

    always @(negedge clk) begin
        mprev <= bus_scl;
        if (mon_clr) begin
            hi_min <= 1000; hi_max <= 0; lo_max <= 0; seen_r <= 0; seen_f <= 0;
            hi_run <= 0; lo_run <= 0;
        end else if (bus_scl) begin
            if (!mprev) begin
                if (seen_f && lo_run > lo_max) lo_max <= lo_run;
                seen_r <= 1; hi_run <= 1;
            end else hi_run <= hi_run + 1;
        end else begin
            if (mprev) begin
                if (seen_r) begin
                    if (hi_run < hi_min) hi_min <= hi_run;
                    if (hi_run > hi_max) hi_max <= hi_run;
                end
                seen_f <= 1; lo_run <= 1;
            end else lo_run <= lo_run + 1;
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int m, input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        for (int i = 0; i < 4000 && !rdy[m]; i++) @(negedge clk);
        cv[m] = 1'b1; cop[m] = op; cdat[m] = d;
        @(posedge clk);
        @(negedge clk);
        cv[m] = 1'b0;
    endtask

    task automatic wait_done(input int m, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (dn[m]) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sclp == 2'b00 && sdap == 2'b00, "R1 reset released", {sclp, sdap}, 0);
        chk(bz == 2'b00, "R2 reset not busy", bz, 0);
        chk(dn == 2'b00 && rdy == 2'b11, "R12 reset idle ready", {dn, rdy}, 3);
    endtask

    task automatic t_misfit();
        bit ok;
        int nb = s_nbytes;
        issue(0, OPW, 8'h12);
        chk(dn[0] == 1'b1, "R12 write in idle done next cycle", dn[0], 1);
        chk(sclp[0] == 0 && sdap[0] == 0 && bus_scl && bus_sda, "R12 lines untouched", {sclp[0], sdap[0]}, 0);
        @(negedge clk);
        chk(dn[0] == 1'b0, "R12 done is a pulse", dn[0], 0);
        issue(0, OPP, 8'h00);
        wait_done(0, ok);
        chk(ok && sclp[0] == 0 && sdap[0] == 0, "R12 stop in idle", {sclp[0], sdap[0]}, 0);
        chk(s_nbytes == nb, "R12 no byte sent", s_nbytes, nb);
    endtask

    task automatic t_single();
        bit ok;
        issue(0, OPS, 8'h00);
        repeat (4) @(negedge clk);
        chk(sdap[0] == 1 && sclp[0] == 0 && bus_scl == 1, "R4 sda low under high scl", {sdap[0], sclp[0]}, 2);
        chk(bz[1] == 1, "R2 other master sees start", bz[1], 1);
        wait_done(0, ok);
        chk(ok && sclp[0] == 1 && ls[0] == 0, "R4 start done, scl held", sclp[0], 1);
        clear_mon();
        issue(0, OPW, 8'hA4);
        wait_done(0, ok);
        chk(ok && ak[0] == 1, "R7 ack on address", ak[0], 1);
        chk(s_byte == 8'hA4, "R7 byte msb first", s_byte, 8'hA4);
        chk(hi_min >= HIGH + 3 && hi_max <= HIGH + 5, "R6 high length", hi_max, HIGH + 4);
        chk(lo_max >= LOW && lo_max <= LOW + 2, "R5 low length", lo_max, LOW + 1);
        issue(0, OPW, 8'h3C);
        wait_done(0, ok);
        chk(ok && ak[0] == 1 && s_byte == 8'h3C, "R7 data byte", s_byte, 8'h3C);
        issue(0, OPP, 8'h00);
        wait_done(0, ok);
        chk(ok && bus_scl && bus_sda && sclp[0] == 0 && sdap[0] == 0, "R11 stop releases", {bus_scl, bus_sda}, 3);
        chk(bz == 2'b00, "R11 busy cleared by stop (R2)", bz, 0);
    endtask

    task automatic t_nack();
        bit ok;
        ack_en = 1'b0;
        issue(0, OPS, 8'h00); wait_done(0, ok);
        issue(0, OPW, 8'h77); wait_done(0, ok);
        chk(ok && ak[0] == 0 && s_byte == 8'h77, "R7 no acknowledge", ak[0], 0);
        issue(0, OPP, 8'h00); wait_done(0, ok);
        ack_en = 1'b1;
    endtask

    task automatic t_stretch();
        bit ok;
        stretch_n = 30;
        issue(0, OPS, 8'h00); wait_done(0, ok);
        clear_mon();
        issue(0, OPW, 8'h96); wait_done(0, ok);
        chk(ok && ak[0] == 1 && s_byte == 8'h96, "R6 data intact under stretch", s_byte, 8'h96);
        chk(lo_max >= 28, "R6 slave held scl low", lo_max, 30);
        chk(hi_min >= HIGH + 3 && hi_max <= HIGH + 5, "R6 high counted after release", hi_min, HIGH + 4);
        stretch_n = 0;
        issue(0, OPP, 8'h00); wait_done(0, ok);
    endtask

    task automatic t_defer();
        bit ok;
        int touched = 0;
        int early = 0;
        issue(0, OPS, 8'h00); wait_done(0, ok);
        issue(1, OPS, 8'h00);
        for (int i = 0; i < 60; i++) begin
            if (sclp[1] || sdap[1]) touched++;
            if (dn[1]) early++;
            @(negedge clk);
        end
        issue(0, OPW, 8'h11); wait_done(0, ok);
        chk(ok && s_byte == 8'h11, "R3 owner keeps bus", s_byte, 8'h11);
        issue(0, OPP, 8'h00); wait_done(0, ok);
        chk(touched == 0 && early == 0, "R3 no access while busy", touched + early, 0);
        wait_done(1, ok);
        chk(ok && ls[1] == 0 && sclp[1] == 1, "R3 start after stop", sclp[1], 1);
        issue(1, OPW, 8'h22); wait_done(1, ok);
        chk(ok && ak[1] == 1 && s_byte == 8'h22, "R3 deferred write", s_byte, 8'h22);
        issue(1, OPP, 8'h00); wait_done(1, ok);
    endtask

    task automatic t_arb();
        bit oka, okb;
        int touched = 0;
        fork issue(0, OPS, 8'h00); issue(1, OPS, 8'h00); join
        fork wait_done(0, oka); wait_done(1, okb); join
        chk(oka && okb, "R9 both starts complete", {oka, okb}, 3);
        fork issue(0, OPW, 8'hA0); issue(1, OPW, 8'hA0); join
        fork wait_done(0, oka); wait_done(1, okb); join
        chk(ls == 2'b00, "R9 identical address no loss", ls, 0);
        chk(ak == 2'b11 && s_byte == 8'hA0, "R9 both see ack", ak, 3);
        fork issue(0, OPW, 8'h35); issue(1, OPW, 8'h55); join
        fork
            wait_done(0, oka);
            begin
                wait_done(1, okb);
                chk(okb && ls[1] == 1, "R8 higher value loses", ls[1], 1);
                chk(sclp[1] == 0 && sdap[1] == 0, "R8 loser releases both", {sclp[1], sdap[1]}, 0);
            end
        join
        chk(oka && ls[0] == 0 && ak[0] == 1, "R9 lower value wins", ls[0], 0);
        chk(s_byte == 8'h35, "R8 winner byte on bus", s_byte, 8'h35);
        for (int i = 0; i < 30; i++) begin
            if (sclp[1] || sdap[1] || !ls[1]) touched++;
            @(negedge clk);
        end
        issue(0, OPP, 8'h00); wait_done(0, oka);
        chk(touched == 0, "R10 loser idle and sticky", touched, 0);
        chk(bz == 2'b00, "R10 winner stop frees bus", bz, 0);
        issue(1, OPS, 8'h00);
        chk(ls[1] == 0, "R10 lost cleared on accept", ls[1], 0);
        wait_done(1, okb);
        issue(1, OPW, 8'h55); wait_done(1, okb);
        chk(okb && ak[1] == 1 && s_byte == 8'h55, "R10 retry succeeds", s_byte, 8'h55);
        issue(1, OPP, 8'h00); wait_done(1, okb);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_clr = 1'b0;
        t_reset();
        t_misfit();
        t_single();
        t_nack();
        t_stretch();
        t_defer();
        t_arb();
        summary();
        $finish;
    end
endmodule